// File: doc/BRIEF.md
# Protected Address Translation Cache

This block is a small fully associative cache of page translations for 4 KB pages. A 32-bit virtual address comes in on a valid/ready request channel together with the access kind (read or write) and the privilege level (user or kernel). Bits 31:12 form the virtual page number and are compared against every stored entry in parallel. Bits 11:0 are the page offset and pass through unchanged. One cycle after a request is accepted, a registered response gives one of three outcomes: a hit with the physical address, a miss, or a protection fault. A miss tells an external page walker or exception path that no mapping is cached. A fault means a mapping was found but the access is not allowed.

Each entry holds a translation plus two protection bits: write allowed, and kernel only. Entries are loaded through a plain refill port. A refill of a page number that is already cached overwrites that entry in place. Otherwise it goes to the lowest-numbered empty entry, or, when all entries are full, to the entry picked by a round-robin pointer. A flush pulse clears every entry in one cycle.

The response channel follows valid/ready rules. A response stays fixed until it is taken. The request side is ready only when the response register is empty or is being emptied in the same cycle. A request held back by a stalled response waits, and is not lost.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, rsp_paddr is {stored PPN, req_vaddr[11:0]}. With VPN 0xFC519 mapped to PPN 0x00152, address 0xFC51908B gives 0x0015208B.
- R2: A request is accepted when req_valid and req_ready are both 1 at a clock edge, and rsp_valid is 1 after that edge. While rsp_valid is 1 and rsp_ready is 0, every response output holds its value and req_ready is 0. req_ready is 1 after reset.
- R3: A request whose VPN matches no valid entry gives rsp_miss=1, rsp_hit=0, rsp_fault=0 and rsp_paddr=0. After reset, all entries are empty.
- R4: A write (req_write=1) that matches an entry with its write-allowed bit at 0 gives rsp_fault=1 and rsp_hit=0. A read of the same entry hits.
- R5: A user access (req_user=1) that matches a kernel-only entry gives rsp_fault=1 and rsp_hit=0. A kernel access (req_user=0) to that entry hits. On a fault, rsp_paddr is 0.
- R6: Every response has exactly one of rsp_hit, rsp_miss and rsp_fault set.
- R7: A refill while empty entries remain writes the lowest-numbered empty entry and evicts nothing, so all 8 entries can be filled and every one of them still hits.
- R8: When all entries are valid, a refill of a new VPN replaces the entry at the round-robin pointer. The pointer starts at entry 0 and advances by one, wrapping, after each such replacement. So the ninth distinct refill evicts the first one, and the tenth evicts the second.
- R9: A refill whose VPN is already cached overwrites that entry's PPN and permissions, and evicts no other entry.
- R10: A flush empties all entries in one cycle, so any later lookup misses until the next refill. A flush and a refill in the same cycle leave the table empty.
- R11: A lookup accepted in the same cycle as a refill sees the table contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can take a lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address (0 unless hit) |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No valid entry for this page |
| rsp_fault | output | 1 | Entry found but access not permitted |
| fill_en | input | 1 | Write one entry this cycle |
| fill_vpn | input | 20 | Virtual page number to store |
| fill_ppn | input | 20 | Physical page number to store |
| fill_wr_ok | input | 1 | Stored write-allowed bit |
| fill_kern_only | input | 1 | Stored kernel-only bit |
| flush | input | 1 | Empty every entry (wins over fill_en) |

## Verification
Lookups are run against an empty table, a partly filled table and a full table. This shows the difference between a true miss and a tag match that passes or fails its permission check. Each permission bit is tested with both access kinds and both privilege levels, so a fault caused by the write bit cannot be confused with one caused by the kernel bit. Refill sequences overwrite an entry in place, fill all eight entries, and then evict two in turn, which shows the empty-entry choice apart from the round-robin choice. A stalled response consumer, a lookup in the same cycle as a refill, and a flush in the same cycle as a refill test the timing corners.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W   = 32;
  parameter int OFS_W  = 12;
  parameter int PA_W   = 32;
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PPN_W = PA_W - OFS_W;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             wr_ok;
    logic             kern_only;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_ent_t         wr_ent,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [VPN_W-1:0] fill_vpn,
  output logic [N_ENT-1:0] valid_vec,
  output logic [N_ENT-1:0] fill_match_vec,
  output logic             look_match,
  output logic [PPN_W-1:0] look_ppn,
  output logic             look_wr_ok,
  output logic             look_kern_only
);
  tlb_ent_t            ents [N_ENT];
  logic [N_ENT-1:0]    look_match_vec;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents[i] <= '0;
      end else if (flush) begin
        ents[i].valid <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        ents[i] <= wr_ent;
      end
    end
    assign valid_vec[i]      = ents[i].valid;
    assign look_match_vec[i] = ents[i].valid && (ents[i].vpn == look_vpn);
    assign fill_match_vec[i] = ents[i].valid && (ents[i].vpn == fill_vpn);
  end

  always_comb begin
    look_ppn       = '0;
    look_wr_ok     = 1'b0;
    look_kern_only = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (look_match_vec[i]) begin
        look_ppn       = look_ppn | ents[i].ppn;
        look_wr_ok     = look_wr_ok | ents[i].wr_ok;
        look_kern_only = look_kern_only | ents[i].kern_only;
      end
    end
  end
  assign look_match = |look_match_vec;
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [N_ENT-1:0] valid_vec,
  input  logic [N_ENT-1:0] fill_match_vec,
  output logic [IDX_W-1:0] victim_idx
);
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] match_idx, free_idx;
  logic             any_match, any_free;

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    any_match = |fill_match_vec;
    any_free  = ~&valid_vec;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (fill_match_vec[i]) match_idx = IDX_W'(i);
      if (!valid_vec[i])     free_idx  = IDX_W'(i);
    end
    if (any_match)     victim_idx = match_idx;
    else if (any_free) victim_idx = free_idx;
    else               victim_idx = rr_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (flush) begin
      rr_ptr <= '0;
    end else if (fill_en && !any_match && !any_free) begin
      rr_ptr <= (rr_ptr == IDX_W'(N_ENT - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_resp_reg.sv
module tlb_resp_reg #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            rsp_ready,
  input  logic [PA_W-1:0] in_paddr,
  input  logic            in_hit,
  input  logic            in_miss,
  input  logic            in_fault,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_hit,
  output logic            rsp_miss,
  output logic            rsp_fault
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= in_paddr;
      rsp_hit   <= in_hit;
      rsp_miss  <= in_miss;
      rsp_fault <= in_fault;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int N_ENT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr_ok,
  input  logic             fill_kern_only,
  input  logic             flush
);
  localparam int IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0] valid_vec, fill_match_vec;
  logic [IDX_W-1:0] victim_idx;
  logic             tag_match, ent_wr_ok, ent_kern_only, perm_bad;
  logic [PPN_W-1:0] ent_ppn;
  logic             accept, c_hit;
  logic [PA_W-1:0]  c_paddr;
  tlb_ent_t         new_ent;

  assign new_ent = '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn,
                     wr_ok: fill_wr_ok, kern_only: fill_kern_only};

  tlb_entry_array #(.N_ENT(N_ENT)) u_array (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(fill_en),
    .wr_idx(victim_idx), .wr_ent(new_ent),
    .look_vpn(req_vaddr[VA_W-1:OFS_W]), .fill_vpn(fill_vpn),
    .valid_vec(valid_vec), .fill_match_vec(fill_match_vec),
    .look_match(tag_match), .look_ppn(ent_ppn),
    .look_wr_ok(ent_wr_ok), .look_kern_only(ent_kern_only)
  );

  tlb_victim_sel #(.N_ENT(N_ENT)) u_victim (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fill_en(fill_en),
    .valid_vec(valid_vec), .fill_match_vec(fill_match_vec),
    .victim_idx(victim_idx)
  );

  assign perm_bad  = (req_write && !ent_wr_ok) || (req_user && ent_kern_only);
  assign c_hit     = tag_match && !perm_bad;
  assign c_paddr   = c_hit ? {ent_ppn, req_vaddr[OFS_W-1:0]} : '0;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  tlb_resp_reg #(.PA_W(PA_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .load(accept), .rsp_ready(rsp_ready),
    .in_paddr(c_paddr), .in_hit(c_hit), .in_miss(!tag_match),
    .in_fault(tag_match && perm_bad),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_fault(rsp_fault)
  );
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_paddr,
  input logic        rsp_hit,
  input logic        rsp_miss,
  input logic        rsp_fault
);
  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

  assert_rsp_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
      $stable(rsp_hit) && $stable(rsp_miss) && $stable(rsp_fault)));

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!rsp_hit || (rsp_paddr[11:0] == $past(req_vaddr[11:0]))));

  assert_no_addr_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_miss || rsp_fault)) |-> (rsp_paddr == 32'h0));
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_fault(rsp_fault)
);

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic        fill_en = 1'b0, fill_wr_ok = 1'b0, fill_kern_only = 1'b0, flush = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic [31:0] pa;
    logic        hit, miss, fault;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_wr_ok(fill_wr_ok), .fill_kern_only(fill_kern_only), .flush(flush)
  );

  task automatic check1(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: a response is taken at the next edge when valid and ready at negedge
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected response actual %h expected none", rsp_paddr);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check1(e.tag, {rsp_paddr, 1'b0, rsp_hit, rsp_miss, rsp_fault},
                      {e.pa, 1'b0, e.hit, e.miss, e.fault});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic push_exp(string tag, logic [31:0] pa, logic h, logic m, logic f);
    exp_t e;
    e.pa = pa; e.hit = h; e.miss = m; e.fault = f; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic lookup(string tag, logic [31:0] va, logic wr, logic usr,
                        logic [31:0] pa, logic h, logic m, logic f);
    @(posedge clk); #1;
    push_exp(tag, pa, h, m, f);
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic wok, logic ko);
    @(posedge clk); #1;
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_wr_ok = wok; fill_kern_only = ko;
    @(posedge clk); #1;
    fill_en = 1'b0;
  endtask

  task automatic do_flush(logic with_fill, logic [19:0] vpn);
    @(posedge clk); #1;
    flush = 1'b1;
    fill_en = with_fill; fill_vpn = vpn; fill_ppn = 20'h77777; fill_wr_ok = 1'b1;
    fill_kern_only = 1'b0;
    @(posedge clk); #1;
    flush = 1'b0; fill_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check1("R2 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check1("R2 reset req_ready", {31'b0, req_ready}, 32'd1);

    lookup("R3 empty miss", 32'hFC51908B, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0);

    fill(20'hFC519, 20'h00152, 1'b1, 1'b0);
    lookup("R1 translate read", 32'hFC51908B, 1'b0, 1'b1, 32'h0015208B, 1'b1, 1'b0, 1'b0);
    lookup("R1 translate write", 32'hFC519FFF, 1'b1, 1'b1, 32'h00152FFF, 1'b1, 1'b0, 1'b0);
    lookup("R3 other page miss", 32'hFC51A000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0);

    fill(20'h00010, 20'h0ABCD, 1'b0, 1'b0);
    lookup("R4 read of readonly", 32'h00010123, 1'b0, 1'b1, 32'h0ABCD123, 1'b1, 1'b0, 1'b0);
    lookup("R4 write of readonly", 32'h00010123, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1);

    fill(20'h00020, 20'h12345, 1'b1, 1'b1);
    lookup("R5 user to kernel page", 32'h00020456, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 1'b1);
    lookup("R5 kernel write", 32'h00020456, 1'b1, 1'b0, 32'h12345456, 1'b1, 1'b0, 1'b0);

    fill(20'h00010, 20'h0BEEF, 1'b1, 1'b0);
    lookup("R9 overwrite in place", 32'h00010ABC, 1'b1, 1'b1, 32'h0BEEFABC, 1'b1, 1'b0, 1'b0);
    lookup("R9 neighbour kept", 32'hFC519000, 1'b0, 1'b1, 32'h00152000, 1'b1, 1'b0, 1'b0);

    for (int i = 0; i < 5; i++) fill(20'h00100 + 20'(i), 20'h50000 + 20'(i), 1'b1, 1'b0);
    lookup("R7 full entry0", 32'hFC519004, 1'b0, 1'b1, 32'h00152004, 1'b1, 1'b0, 1'b0);
    lookup("R7 full entry7", 32'h00104010, 1'b0, 1'b1, 32'h50004010, 1'b1, 1'b0, 1'b0);
    lookup("R7 full entry3", 32'h00100010, 1'b0, 1'b1, 32'h50000010, 1'b1, 1'b0, 1'b0);

    fill(20'h00200, 20'h60000, 1'b1, 1'b0);
    lookup("R8 first evicted", 32'hFC51908B, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0);
    lookup("R8 new present", 32'h00200008, 1'b0, 1'b1, 32'h60000008, 1'b1, 1'b0, 1'b0);
    fill(20'h00201, 20'h60001, 1'b1, 1'b0);
    lookup("R8 second evicted", 32'h00010ABC, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0);
    lookup("R8 third kept", 32'h00020000, 1'b0, 1'b0, 32'h12345000, 1'b1, 1'b0, 1'b0);

    // R11: lookup in the same cycle as the refill of that page
    @(posedge clk); #1;
    push_exp("R11 same cycle old view", 32'h0, 1'b0, 1'b1, 1'b0);
    req_vaddr = 32'h00300020; req_write = 1'b0; req_user = 1'b1; req_valid = 1'b1;
    fill_en = 1'b1; fill_vpn = 20'h00300; fill_ppn = 20'h70000; fill_wr_ok = 1'b1;
    fill_kern_only = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0; fill_en = 1'b0;
    lookup("R11 later hit", 32'h00300020, 1'b0, 1'b1, 32'h70000020, 1'b1, 1'b0, 1'b0);

    // R2: stalled consumer
    @(posedge clk); #1;
    rsp_ready = 1'b0;
    push_exp("R2 stalled response", 32'h60000044, 1'b1, 1'b0, 1'b0);
    req_vaddr = 32'h00200044; req_write = 1'b0; req_user = 1'b1; req_valid = 1'b1;
    @(posedge clk); #1;
    req_vaddr = 32'h00201055;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check1("R2 stall valid", {31'b0, rsp_valid}, 32'd1);
      check1("R2 stall ready", {31'b0, req_ready}, 32'd0);
      check1("R2 stall paddr", rsp_paddr, 32'h60000044);
    end
    @(posedge clk); #1;
    push_exp("R2 queued request", 32'h60001055, 1'b1, 1'b0, 1'b0);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;

    do_flush(1'b0, 20'h0);
    lookup("R10 flushed miss", 32'h00200044, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0);
    fill(20'h00400, 20'h01234, 1'b1, 1'b0);
    do_flush(1'b1, 20'h00500);
    lookup("R10 flush beats fill", 32'h00500000, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0);
    lookup("R10 earlier fill gone", 32'h00400000, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0);

    repeat (4) @(posedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: missing responses actual %0d pending expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule